// File: doc/BRIEF.md
# Peripheral Clock Gating Controller

This block holds one clock-enable bit for each peripheral of a subsystem and uses those bits to gate a shared master clock. Software controls the bits through a small word-addressed register bus. One write port turns clocks on and a separate write port turns them off. In both ports a 1 in bit position *n* acts on the peripheral whose identifier is *n*, and a 0 leaves that peripheral untouched. A read-only state word mirrors every enable bit.

For each identifier the block drives two outputs. The first is a registered clock-enable, for flows that gate inside the peripheral. The second is a gated clock taken from a latch-based glitch-free gate. When a clock is switched off it stops at once. The block does not wait for the peripheral to finish any work it has in progress. After reset every clock is off. The two lowest identifiers are reserved and can never be enabled.

Top module: `periph_clk_gate_ctrl`

## Requirements
- R1: A clock edge with `rst_n` low clears every enable bit, so `periph_en_o` and the state word both read zero.
- R2: A bus write (`bus_sel`=1, `bus_wr`=1) to address 0 (turn-on port) sets each enable bit whose data bit is 1, on the clock edge that accepts the write. Enable bits whose data bit is 0 keep their value.
- R3: A bus write to address 1 (turn-off port) clears each enable bit whose data bit is 1, on the edge that accepts the write. Enable bits whose data bit is 0 keep their value.
- R4: A bus read (`bus_sel`=1, `bus_wr`=0) at address 2 returns the current enable state combinationally in the same cycle. Bit *n* holds identifier *n*.
- R5: A read at address 0, 1 or 3, and any cycle without a read, return zero on `bus_rdata`. A write to address 3 changes no enable bit.
- R6: A write to address 2 (the read-only state word) changes no enable bit.
- R7: Identifiers 0 and 1 are reserved. Their enable bits, their state bits and their gated clocks stay at zero whatever is written.
- R8: `periph_en_o[n]` drops on the very edge that accepts a turn-off write for bit *n*. The gated clock then completes only the high phase that began at that edge and produces no later rising edge.
- R9: `periph_clk_o[n]` is high only during a master-clock high phase. It follows the enable value held in the low phase just before that high phase, so a turn-on accepted at edge *k* gives its first gated pulse at edge *k*+1.
- R10: In a cycle with no accepted write to address 0 or 1, every enable bit keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock shared by all peripherals |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address: 0 turn-on, 1 turn-off, 2 state |
| bus_wdata | input | 32 | Write data, one bit per identifier |
| bus_rdata | output | 32 | Read data, zero unless the state word is read |
| periph_en_o | output | 32 | Registered clock-enable per identifier |
| periph_clk_o | output | 32 | Glitch-free gated clock per identifier |

## Verification
The assertions assume that the bus inputs are steady around the rising edge and never carry X while `rst_n` is high. They also assume that the master clock has a clean low phase before each high phase, because the gate latch samples the enable during that phase. The bench drives every bus signal at the falling edge and holds it through the next rising edge. It picks addresses only from the four-word map and leaves `bus_sel` low in idle cycles. The gated-clock comparison starts only after one reset edge has given the latch a known value.

// File: rtl/pcg_pkg.sv
// Package: pcg_pkg
// Shared address map and decode type for the peripheral clock gating
// controller. Assumes a four-word, word-addressed register window.
package pcg_pkg;
    localparam int PCG_ADDR_W = 2;

    localparam logic [PCG_ADDR_W-1:0] ADDR_TURN_ON  = 2'd0;
    localparam logic [PCG_ADDR_W-1:0] ADDR_TURN_OFF = 2'd1;
    localparam logic [PCG_ADDR_W-1:0] ADDR_STATE    = 2'd2;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_TURN_ON,
        ACC_TURN_OFF,
        ACC_READ_STATE
    } pcg_access_e;
endpackage

// File: rtl/pcg_regif.sv
// Module: pcg_regif
// Decodes one register access per cycle into turn-on / turn-off strobes with
// their bit masks and builds the read data. Purely combinational.
// Assumes at most one access per cycle; reserved bits are removed from the
// turn-on mask here so the enable bank never sees them.
module pcg_regif
    import pcg_pkg::*;
#(
    parameter int NUM_IDS = 32,
    parameter int DATA_W  = 32,
    parameter logic [NUM_IDS-1:0] ALLOWED = '1
) (
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [PCG_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    input  logic [NUM_IDS-1:0]    state_i,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  on_stb_o,
    output logic                  off_stb_o,
    output logic [NUM_IDS-1:0]    on_mask_o,
    output logic [NUM_IDS-1:0]    off_mask_o
);
    localparam int PAD_W = DATA_W - NUM_IDS;

    pcg_access_e acc;

    // Classify the current bus cycle.
    always_comb begin
        acc = ACC_NONE;
        if (bus_sel) begin
            if (bus_wr && bus_addr == ADDR_TURN_ON)       acc = ACC_TURN_ON;
            else if (bus_wr && bus_addr == ADDR_TURN_OFF) acc = ACC_TURN_OFF;
            else if (!bus_wr && bus_addr == ADDR_STATE)   acc = ACC_READ_STATE;
        end
    end

    // Strobes and masks for the enable bank.
    always_comb begin
        on_stb_o   = (acc == ACC_TURN_ON);
        off_stb_o  = (acc == ACC_TURN_OFF);
        on_mask_o  = bus_wdata[NUM_IDS-1:0] & ALLOWED;
        off_mask_o = bus_wdata[NUM_IDS-1:0];
    end

    // Read data: the state word only, zero otherwise.
    generate
        if (PAD_W > 0) begin : g_pad
            always_comb begin
                bus_rdata = '0;
                if (acc == ACC_READ_STATE) bus_rdata = {{PAD_W{1'b0}}, state_i};
            end
        end else begin : g_nopad
            always_comb begin
                bus_rdata = '0;
                if (acc == ACC_READ_STATE) bus_rdata = state_i;
            end
        end
    endgenerate
endmodule

// File: rtl/pcg_enable_bank.sv
// Module: pcg_enable_bank
// Holds one enable flop per peripheral identifier. Turn-on strobes OR the
// mask in and turn-off strobes clear it; if both arrive together, clear wins.
// Assumes masks are already stripped of reserved identifiers.
module pcg_enable_bank #(
    parameter int NUM_IDS = 32,
    parameter logic [NUM_IDS-1:0] ALLOWED = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               on_stb_i,
    input  logic [NUM_IDS-1:0] on_mask_i,
    input  logic               off_stb_i,
    input  logic [NUM_IDS-1:0] off_mask_i,
    output logic [NUM_IDS-1:0] en_q
);
    logic [NUM_IDS-1:0] set_v;
    logic [NUM_IDS-1:0] clr_v;
    logic [NUM_IDS-1:0] en_d;

    // Next-state: set then clear, so clear has priority.
    always_comb begin
        set_v = on_stb_i  ? on_mask_i  : '0;
        clr_v = off_stb_i ? off_mask_i : '0;
        en_d  = ((en_q | set_v) & ~clr_v) & ALLOWED;
    end

    // Enable flops with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    // R1: reset edge leaves all clocks off.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (en_q == '0));

    // R2: every requested bit is on after a turn-on strobe.
    a_r2_on_applies: assert property (@(posedge clk) disable iff (!rst_n)
        (on_stb_i && !off_stb_i) |=> ((en_q & $past(on_mask_i)) == $past(on_mask_i)));

    // R3 and R8: every requested bit is off right after a turn-off strobe.
    a_r3_off_applies: assert property (@(posedge clk) disable iff (!rst_n)
        off_stb_i |=> ((en_q & $past(off_mask_i)) == '0));

    // R10: no strobe, no change.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!on_stb_i && !off_stb_i) |=> $stable(en_q));

    // R7: reserved identifiers never enabled.
    a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_q & ~ALLOWED) == '0));
endmodule

// File: rtl/pcg_clk_gate.sv
// Module: pcg_clk_gate
// One gated clock. The latch variant captures the enable while the clock is
// low and ANDs it with the clock, so a change of enable near the rising edge
// never shortens a pulse. The direct variant is a plain AND for flows that
// only use the clock-enable. Assumes the enable changes only after rising edges.
module pcg_clk_gate #(
    parameter bit LATCH_GATE = 1'b1
) (
    input  logic clk,
    input  logic en_i,
    output logic gclk_o
);
    generate
        if (LATCH_GATE) begin : g_latch
            logic en_lat;

            // Transparent while clk is low, holds during the high phase.
            always_latch begin
                if (!clk) en_lat = en_i;
            end

            assign gclk_o = clk & en_lat;
        end else begin : g_direct
            assign gclk_o = clk & en_i;
        end
    endgenerate
endmodule

// File: rtl/periph_clk_gate_ctrl.sv
// Module: periph_clk_gate_ctrl
// Top of the peripheral clock gating controller: register decode, enable
// bank and one clock gate per identifier. Identifiers below NUM_RSVD are
// reserved and held off. Assumes NUM_IDS <= DATA_W.
module periph_clk_gate_ctrl
    import pcg_pkg::*;
#(
    parameter int NUM_IDS    = 32,
    parameter int DATA_W     = 32,
    parameter int NUM_RSVD   = 2,
    parameter bit LATCH_GATE = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [PCG_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic [NUM_IDS-1:0]    periph_en_o,
    output logic [NUM_IDS-1:0]    periph_clk_o
);
    localparam logic [NUM_IDS-1:0] ALLOWED = ~((NUM_IDS)'((64'd1 << NUM_RSVD) - 64'd1));

    logic               on_stb;
    logic               off_stb;
    logic [NUM_IDS-1:0] on_mask;
    logic [NUM_IDS-1:0] off_mask;
    logic [NUM_IDS-1:0] en_q;

    pcg_regif #(
        .NUM_IDS (NUM_IDS),
        .DATA_W  (DATA_W),
        .ALLOWED (ALLOWED)
    ) u_regif (
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .state_i    (en_q),
        .bus_rdata  (bus_rdata),
        .on_stb_o   (on_stb),
        .off_stb_o  (off_stb),
        .on_mask_o  (on_mask),
        .off_mask_o (off_mask)
    );

    pcg_enable_bank #(
        .NUM_IDS (NUM_IDS),
        .ALLOWED (ALLOWED)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .on_stb_i   (on_stb),
        .on_mask_i  (on_mask),
        .off_stb_i  (off_stb),
        .off_mask_i (off_mask),
        .en_q       (en_q)
    );

    assign periph_en_o = en_q;

    // One gate per identifier.
    generate
        for (genvar g = 0; g < NUM_IDS; g++) begin : g_gate
            pcg_clk_gate #(.LATCH_GATE(LATCH_GATE)) u_gate (
                .clk    (clk),
                .en_i   (en_q[g]),
                .gclk_o (periph_clk_o[g])
            );
        end
    endgenerate

    // R4: a state read returns the enable outputs.
    a_r4_state_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == ADDR_STATE) |-> (bus_rdata[NUM_IDS-1:0] == periph_en_o));

    // R5: nothing but a state read drives read data.
    a_r5_rdata_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr && bus_addr == ADDR_STATE) |-> (bus_rdata == '0));

    // R5 and R6: writes outside the two control ports leave the enables alone.
    a_r6_other_writes_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr != ADDR_TURN_ON && bus_addr != ADDR_TURN_OFF)
        |=> $stable(periph_en_o));
endmodule

// File: tb/periph_clk_gate_ctrl_tb.sv
`timescale 1ns/1ps
module periph_clk_gate_ctrl_tb;
    localparam int N = 32;
    localparam logic [31:0] ALLOWED_M = 32'hFFFF_FFFC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic [N-1:0] periph_en_o;
    logic [N-1:0] periph_clk_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    periph_clk_gate_ctrl u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_sel      (bus_sel),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .periph_en_o  (periph_en_o),
        .periph_clk_o (periph_clk_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, compared one step after every rising edge.
    bit [31:0] ref_st = 32'd0;
    bit [31:0] ref_prev = 32'd0;
    bit [31:0] exp_rd;
    bit        primed = 1'b0;
    bit        was_rst;

    always @(posedge clk) begin
        ref_prev = ref_st;
        was_rst  = !rst_n;
        if (!rst_n) ref_st = 32'd0;
        else if (bus_sel && bus_wr) begin
            if (bus_addr == 2'd0) ref_st = ref_st | (bus_wdata & ALLOWED_M);
            else if (bus_addr == 2'd1) ref_st = ref_st & ~bus_wdata;
        end
        exp_rd = (bus_sel && !bus_wr && bus_addr == 2'd2) ? ref_st : 32'd0;
        #1;
        if (!done) begin
            chk("R1/R2/R3/R10 enable state", periph_en_o, ref_st);
            chk("R4/R5 read data", bus_rdata, exp_rd);
            if (primed) chk("R8/R9 gated clock high phase", periph_clk_o, ref_prev);
        end
        if (was_rst) primed = 1'b1;
    end

    // Gated-clock pulse counter for identifier 5.
    int pulses5 = 0;
    always @(posedge periph_clk_o[5]) pulses5++;

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 32'd0;
    endtask

    task automatic bus_read_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    initial begin
        int snap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        bus_read_chk(2'd2, 32'd0, "R1 state after reset");
        chk("R1 enables after reset", periph_en_o, 32'd0);

        bus_write(2'd0, 32'hFFFF_FFFF);
        bus_read_chk(2'd2, 32'hFFFF_FFFC, "R2 R7 set all, reserved stay off");
        bus_write(2'd1, 32'h0000_FF00);
        bus_read_chk(2'd2, 32'hFFFF_00FC, "R3 clear byte 1");
        bus_write(2'd0, 32'd0);
        bus_read_chk(2'd2, 32'hFFFF_00FC, "R2 zero set data no change");
        bus_write(2'd1, 32'd0);
        bus_read_chk(2'd2, 32'hFFFF_00FC, "R3 zero clear data no change");
        bus_write(2'd2, 32'd0);
        bus_read_chk(2'd2, 32'hFFFF_00FC, "R6 write to state ignored");
        bus_write(2'd3, 32'hFFFF_FFFF);
        bus_write(2'd3, 32'd0);
        bus_read_chk(2'd2, 32'hFFFF_00FC, "R5 write to unmapped ignored");
        bus_read_chk(2'd0, 32'd0, "R5 turn-on port reads zero");
        bus_read_chk(2'd1, 32'd0, "R5 turn-off port reads zero");
        bus_read_chk(2'd3, 32'd0, "R5 unmapped reads zero");
        bus_write(2'd1, 32'h0000_0003);
        bus_write(2'd0, 32'h0000_0003);
        chk("R7 reserved gated clocks low", {30'd0, periph_clk_o[1:0]}, 32'd0);
        bus_read_chk(2'd2, 32'hFFFF_00FC, "R7 reserved cannot be set");

        // R9: ten full cycles after a turn-on give ten gated pulses.
        bus_write(2'd1, 32'hFFFF_FFFF);
        bus_write(2'd0, 32'h0000_0020);
        snap = pulses5;
        repeat (10) @(negedge clk);
        chk("R9 pulses after turn-on", pulses5 - snap, 10);

        // R8: after the turn-off edge no further pulse.
        bus_write(2'd1, 32'h0000_0020);
        chk("R8 enable dropped at once", {31'd0, periph_en_o[5]}, 32'd0);
        snap = pulses5;
        repeat (5) @(negedge clk);
        chk("R8 no pulse after turn-off", pulses5 - snap, 0);

        // Mixed traffic checked by the model every cycle.
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            bus_sel   = ($urandom % 4) != 0;
            bus_wr    = $urandom % 2;
            bus_addr  = 2'($urandom % 4);
            bus_wdata = $urandom;
            if (i == 200) rst_n = 1'b0;
            if (i == 202) rst_n = 1'b1;
        end
        @(negedge clk);
        bus_sel = 1'b0;
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        done = 1'b1;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule